// File: doc/BRIEF.md
# Rename Stage Stall Controller

This block is the flow and stall controller for one thread of a register-rename pipeline stage. Each cycle it may receive a group of instructions from decode, each with a sequence number and a serializing flag. It also receives full indications from the downstream reorder buffer, issue queue, load/store queue and physical-register pool, a dispatch count, and a squash request that carries a sequence number. Register mapping and free-list handling live elsewhere. This block decides when instructions move on, when decode must hold, and what happens to buffered work on a squash.

Every accepted instruction passes through a skid buffer. The buffer's depth is derived from the decode-to-rename feedback latency and from the two stage widths, so it can absorb everything decode has in flight when it is told to stop. The controller steps through six statuses. It raises a level block toward decode and a one-cycle unblock pulse toward decode. It holds a serializing instruction until the downstream pipeline is empty, and it keeps per-status cycle counters and counters of full-indication events.

Top module: `rename_stall_ctrl`

## Requirements
- R1: After reset, `status` is Idle (encoding Idle=0, Running=1, Blocked=2, Unblocking=3, SerializeStall=4, Squashing=5). `blk_dec`, `unblk_dec`, `ren_vld` and `inflight` are 0, and all event counters are 0.
- R2: The skid buffer holds 2*FB_DLY*DEC_W+REN_W entries (6 by default). Instructions buffered while Blocked are all emitted later, oldest first, and none is lost up to that depth.
- R3: Valid decode input is written to the buffer at one clock edge and emitted at the next. Up to REN_W instructions are emitted per cycle, oldest in slot 0 (`ren_seq[SEQ_W-1:0]`). The status is Running while work remains and Idle once the buffer is empty with no valid input.
- R4: When any full indication is set and there is buffered or incoming work, the status becomes Blocked on the next edge with `blk_dec`=1, and nothing is emitted while Blocked. A full indication with no work leaves the status unchanged.
- R5: When every full indication clears, Blocked becomes Unblocking. Unblocking drains the buffer. At the edge where the buffer becomes empty, the status becomes Running, `blk_dec` drops and `unblk_dec` pulses for one cycle.
- R6: A serializing instruction at the head of the buffer is not emitted with others. It is held and the status becomes SerializeStall with `blk_dec`=1. It is emitted alone with `ren_ser`=1 once `inflight` is 0 and no full indication is set, and the status then becomes Unblocking.
- R7: A squash while Blocked or Unblocking moves the status to Squashing on the next edge. It empties the buffer, drops `blk_dec` and pulses `unblk_dec`.
- R8: A squash in SerializeStall whose sequence number is greater than or equal to that of the held instruction keeps the held instruction and gives no unblock pulse. The Squashing status lasts one cycle and returns to SerializeStall. `blk_dec` is raised again one edge later, and the held instruction is emitted afterwards.
- R9: A squash in SerializeStall whose sequence number is smaller than that of the held instruction drops the held instruction and pulses `unblk_dec`. Squashing then moves to Running.
- R10: During a squash, `sq_mark[i]` is set combinationally for each valid decode slot whose sequence number is greater than `sq_seq` (unsigned compare). Those slots are discarded. Older valid slots are kept and emitted later.
- R11: `inflight` rises by the number emitted and falls by `disp_cnt` each cycle, and it saturates at 0 instead of going negative.
- R12: `state_cyc` holds one cycle counter per status, with the counter for status encoding k at bits [k*CNT_W +: CNT_W]. A counter advances at each edge where the status had that value.
- R13: `full_evts` counts rising edges of each full indication, in slots 0..3 for ROB, issue queue, load/store queue and free registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_vld | input | DEC_W | Valid flag per decode slot |
| dec_seq | input | DEC_W*SEQ_W | Sequence number per decode slot |
| dec_ser | input | DEC_W | Serializing flag per decode slot |
| rob_full | input | 1 | Reorder buffer full |
| iq_full | input | 1 | Issue queue full |
| lsq_full | input | 1 | Load/store queue full |
| regs_empty | input | 1 | No free physical registers |
| disp_cnt | input | IFL_W | Instructions dispatched downstream this cycle |
| sq_vld | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash sequence number |
| status | output | 3 | Current status encoding |
| blk_dec | output | 1 | Block toward decode (level) |
| unblk_dec | output | 1 | Unblock toward decode (one-cycle pulse) |
| sq_mark | output | DEC_W | Decode slot marked squashed |
| ren_vld | output | REN_W | Valid flag per output slot |
| ren_seq | output | REN_W*SEQ_W | Sequence number per output slot |
| ren_ser | output | REN_W | Output slot carries a serializing instruction |
| inflight | output | IFL_W | Instructions emitted but not yet dispatched |
| state_cyc | output | 6*CNT_W | Cycle counters per status |
| full_evts | output | 4*CNT_W | Rising-edge counters per full indication |

## Verification
A squash can arrive in the same cycle as a stall or as a pending serializing hold. In that case the squash must win, and its effect on the unblock pulse depends on the status it interrupts. The bench provokes this by asserting a squash while a full indication is still set, both in Blocked and in SerializeStall. It also gives the SerializeStall case one squash point that is older and one that is younger than the held instruction. It judges the result by the unblock pulse, the return status and whether the held instruction later appears on the output. A squash that lands together with a mixed-age decode group is judged by `sq_mark` in the same cycle and by which sequence numbers are emitted afterwards.

// File: rtl/rename_stall_ctrl.sv
module rename_stall_ctrl #(
  parameter int DEC_W  = 2,
  parameter int REN_W  = 2,
  parameter int FB_DLY = 1,
  parameter int SEQ_W  = 8,
  parameter int IFL_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DEC_W-1:0]       dec_vld,
  input  logic [DEC_W*SEQ_W-1:0] dec_seq,
  input  logic [DEC_W-1:0]       dec_ser,
  input  logic                   rob_full,
  input  logic                   iq_full,
  input  logic                   lsq_full,
  input  logic                   regs_empty,
  input  logic [IFL_W-1:0]       disp_cnt,
  input  logic                   sq_vld,
  input  logic [SEQ_W-1:0]       sq_seq,
  output logic [2:0]             status,
  output logic                   blk_dec,
  output logic                   unblk_dec,
  output logic [DEC_W-1:0]       sq_mark,
  output logic [REN_W-1:0]       ren_vld,
  output logic [REN_W*SEQ_W-1:0] ren_seq,
  output logic [REN_W-1:0]       ren_ser,
  output logic [IFL_W-1:0]       inflight,
  output logic [6*CNT_W-1:0]     state_cyc,
  output logic [4*CNT_W-1:0]     full_evts
);
  localparam int DEPTH = 2 * FB_DLY * DEC_W + REN_W;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int NST   = 6;
  localparam int NFULL = 4;

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_BLK, S_UNB, S_SER, S_SQ} st_e;
  typedef struct packed {
    logic             ser;
    logic [SEQ_W-1:0] seq;
  } ent_t;

  st_e              st, st_n;
  ent_t             q   [DEPTH];
  ent_t             q_n [DEPTH];
  logic [CW-1:0]    cnt, cnt_n, npop, shift;
  logic             resume, resume_n, hold_vld, hold_vld_n, blk_n, unblk_n;
  logic [SEQ_W-1:0] hold_seq, hold_seq_n;
  logic [DEC_W-1:0] acc;
  logic [REN_W-1:0] take, emit_vld_n, emit_ser_n;
  logic [REN_W*SEQ_W-1:0] emit_seq_n;
  logic [IFL_W-1:0] nemit, ifl_n;
  logic [IFL_W:0]   ifl_sum;
  logic             stall, can_pop, ser_take, rel, ok;
  logic [NFULL-1:0] fulls, fulls_q;
  logic [CNT_W-1:0] scyc [NST];
  logic [CNT_W-1:0] fev  [NFULL];

  assign fulls   = {regs_empty, lsq_full, iq_full, rob_full};
  assign stall   = |fulls;
  assign status  = st;
  assign can_pop = !stall && !sq_vld && (st == S_IDLE || st == S_RUN || st == S_UNB);
  assign rel     = (st == S_SER) && hold_vld && !resume && (inflight == '0) && !stall && !sq_vld;

  for (genvar g = 0; g < DEC_W; g++) begin : g_dec
    assign sq_mark[g] = sq_vld && dec_vld[g] && (dec_seq[g*SEQ_W +: SEQ_W] > sq_seq);
    assign acc[g]     = dec_vld[g] && !sq_mark[g];
  end
  for (genvar g = 0; g < NST; g++) begin : g_scyc
    assign state_cyc[g*CNT_W +: CNT_W] = scyc[g];
  end
  for (genvar g = 0; g < NFULL; g++) begin : g_fev
    assign full_evts[g*CNT_W +: CNT_W] = fev[g];
  end

  always_comb begin
    ok = 1'b1;
    npop = '0;
    take = '0;
    for (int j = 0; j < REN_W; j++) begin
      if (can_pop && ok && CW'(j) < cnt && !q[j].ser) begin
        take[j] = 1'b1;
        npop = npop + CW'(1);
      end else begin
        ok = 1'b0;
      end
    end
    ser_take = can_pop && !hold_vld && (cnt != '0) && q[0].ser;
    shift = ser_take ? CW'(1) : npop;

    for (int e = 0; e < DEPTH; e++) begin
      q_n[e] = '0;
      for (int k = 0; k <= REN_W; k++)
        if (shift == CW'(k) && e + k < DEPTH) q_n[e] = q[(e + k) % DEPTH];
    end
    cnt_n = sq_vld ? '0 : cnt - shift;
    for (int i = 0; i < DEC_W; i++) begin
      if (acc[i] && cnt_n < CW'(DEPTH)) begin
        for (int e = 0; e < DEPTH; e++)
          if (CW'(e) == cnt_n) q_n[e] = '{ser: dec_ser[i], seq: dec_seq[i*SEQ_W +: SEQ_W]};
        cnt_n = cnt_n + CW'(1);
      end
    end

    emit_vld_n = '0;
    emit_ser_n = '0;
    emit_seq_n = '0;
    nemit = '0;
    for (int j = 0; j < REN_W; j++) begin
      if (take[j]) begin
        emit_vld_n[j] = 1'b1;
        emit_seq_n[j*SEQ_W +: SEQ_W] = q[j].seq;
        nemit = nemit + IFL_W'(1);
      end
    end
    if (rel) begin
      emit_vld_n[0] = 1'b1;
      emit_ser_n[0] = 1'b1;
      emit_seq_n[SEQ_W-1:0] = hold_seq;
      nemit = IFL_W'(1);
    end
    ifl_sum = {1'b0, inflight} + {1'b0, nemit};
    ifl_n = ({1'b0, disp_cnt} > ifl_sum) ? '0 : IFL_W'(ifl_sum - {1'b0, disp_cnt});
  end

  always_comb begin
    st_n = st;
    blk_n = blk_dec;
    unblk_n = 1'b0;
    resume_n = resume;
    hold_vld_n = hold_vld;
    hold_seq_n = hold_seq;
    if (ser_take) begin
      hold_vld_n = 1'b1;
      hold_seq_n = q[0].seq;
    end
    if (sq_vld) begin
      st_n = S_SQ;
      blk_n = 1'b0;
      if (st == S_SER && hold_vld && hold_seq <= sq_seq) begin
        resume_n = 1'b1;
      end else begin
        resume_n = 1'b0;
        hold_vld_n = 1'b0;
        unblk_n = (st == S_BLK) || (st == S_UNB) || (st == S_SER);
      end
    end else begin
      case (st)
        S_IDLE, S_RUN: begin
          if (stall && (cnt != '0 || |dec_vld)) begin
            st_n = S_BLK;
            blk_n = 1'b1;
          end else if (ser_take) begin
            st_n = S_SER;
            blk_n = 1'b1;
          end else begin
            st_n = (cnt_n == '0) ? S_IDLE : S_RUN;
          end
        end
        S_BLK: if (!stall) st_n = S_UNB;
        S_UNB: begin
          if (stall) begin
            st_n = S_BLK;
          end else if (ser_take) begin
            st_n = S_SER;
          end else if (cnt_n == '0) begin
            st_n = S_RUN;
            blk_n = 1'b0;
            unblk_n = 1'b1;
          end
        end
        S_SER: begin
          if (resume) begin
            blk_n = 1'b1;
            resume_n = 1'b0;
          end else if (rel) begin
            hold_vld_n = 1'b0;
            st_n = S_UNB;
          end
        end
        S_SQ: st_n = resume ? S_SER : S_RUN;
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      for (int e = 0; e < DEPTH; e++) q[e] <= '0;
      resume <= 1'b0;
      hold_vld <= 1'b0;
      hold_seq <= '0;
      blk_dec <= 1'b0;
      unblk_dec <= 1'b0;
      ren_vld <= '0;
      ren_seq <= '0;
      ren_ser <= '0;
      inflight <= '0;
      fulls_q <= '0;
      for (int k = 0; k < NST; k++) scyc[k] <= '0;
      for (int k = 0; k < NFULL; k++) fev[k] <= '0;
    end else begin
      st <= st_n;
      cnt <= cnt_n;
      for (int e = 0; e < DEPTH; e++) q[e] <= q_n[e];
      resume <= resume_n;
      hold_vld <= hold_vld_n;
      hold_seq <= hold_seq_n;
      blk_dec <= blk_n;
      unblk_dec <= unblk_n;
      ren_vld <= emit_vld_n;
      ren_seq <= emit_seq_n;
      ren_ser <= emit_ser_n;
      inflight <= ifl_n;
      fulls_q <= fulls;
      for (int k = 0; k < NST; k++)
        if (st == st_e'(k)) scyc[k] <= scyc[k] + CNT_W'(1);
      for (int k = 0; k < NFULL; k++)
        if (fulls[k] && !fulls_q[k]) fev[k] <= fev[k] + CNT_W'(1);
    end
  end
endmodule

module rename_stall_ctrl_chk #(
  parameter int DEPTH = 6,
  parameter int CW    = 3,
  parameter int REN_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       st,
  input logic [CW-1:0]    cnt,
  input logic             resume,
  input logic             blk_dec,
  input logic             unblk_dec,
  input logic             sq_vld,
  input logic [REN_W-1:0] ren_vld
);
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_quiet_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd2) |-> (ren_vld == '0));
  p_unblk_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    unblk_dec |=> !unblk_dec);
  p_ser_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd4 && !resume) |-> blk_dec);
  p_squash_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sq_vld |=> (st == 3'd5));
  p_squash_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd5 && !sq_vld) |=> (st == 3'd1 || st == 3'd4));
  p_resume_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd4 && resume && !sq_vld) |=> blk_dec);
endmodule

bind rename_stall_ctrl rename_stall_ctrl_chk #(.DEPTH(DEPTH), .CW(CW), .REN_W(REN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(status), .cnt(cnt), .resume(resume),
  .blk_dec(blk_dec), .unblk_dec(unblk_dec), .sq_vld(sq_vld), .ren_vld(ren_vld)
);

// File: tb/rename_stall_ctrl_bench.sv
module rename_stall_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  dec_vld = '0;
  logic [15:0] dec_seq = '0;
  logic [1:0]  dec_ser = '0;
  logic        rob_full = 1'b0, iq_full = 1'b0, lsq_full = 1'b0, regs_empty = 1'b0;
  logic [7:0]  disp_cnt = '0;
  logic        sq_vld = 1'b0;
  logic [7:0]  sq_seq = '0;
  logic [2:0]  status;
  logic        blk_dec, unblk_dec;
  logic [1:0]  sq_mark, ren_vld, ren_ser;
  logic [15:0] ren_seq;
  logic [7:0]  inflight;
  logic [95:0] state_cyc;
  logic [63:0] full_evts;
  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  rename_stall_ctrl u_rename_stall_ctrl (
    .clk(clk), .rst_n(rst_n), .dec_vld(dec_vld), .dec_seq(dec_seq), .dec_ser(dec_ser),
    .rob_full(rob_full), .iq_full(iq_full), .lsq_full(lsq_full), .regs_empty(regs_empty),
    .disp_cnt(disp_cnt), .sq_vld(sq_vld), .sq_seq(sq_seq), .status(status),
    .blk_dec(blk_dec), .unblk_dec(unblk_dec), .sq_mark(sq_mark), .ren_vld(ren_vld),
    .ren_seq(ren_seq), .ren_ser(ren_ser), .inflight(inflight), .state_cyc(state_cyc),
    .full_evts(full_evts)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_dec(input logic [1:0] v, input int s0, input int s1, input logic [1:0] ser);
    dec_vld = v;
    dec_seq = {8'(s1), 8'(s0)};
    dec_ser = ser;
  endtask

  task automatic clr_dec();
    set_dec(2'b00, 0, 0, 2'b00);
  endtask

  task automatic t_reset();
    chk("R1 status", int'(status), 0);
    chk("R1 blk", int'(blk_dec), 0);
    chk("R1 unblk", int'(unblk_dec), 0);
    chk("R1 ren_vld", int'(ren_vld), 0);
    chk("R1 inflight", int'(inflight), 0);
    chk("R1 full_evts", int'(full_evts != '0), 0);
  endtask

  task automatic t_flow();
    set_dec(2'b11, 10, 11, 2'b00);
    tick(); clr_dec();
    chk("R3 running", int'(status), 1);
    chk("R3 not yet out", int'(ren_vld), 0);
    tick();
    chk("R3 out vld", int'(ren_vld), 3);
    chk("R3 slot0", int'(ren_seq[7:0]), 10);
    chk("R3 slot1", int'(ren_seq[15:8]), 11);
    chk("R3 idle", int'(status), 0);
    chk("R11 inflight up", int'(inflight), 2);
    disp_cnt = 2;
    tick(); disp_cnt = 0;
    chk("R3 out quiet", int'(ren_vld), 0);
    chk("R11 inflight down", int'(inflight), 0);
    disp_cnt = 3;
    tick(); disp_cnt = 0;
    chk("R11 saturate", int'(inflight), 0);
  endtask

  task automatic t_block();
    iq_full = 1'b1;
    set_dec(2'b11, 20, 21, 2'b00);
    tick();
    chk("R4 blocked", int'(status), 2);
    chk("R4 blk", int'(blk_dec), 1);
    chk("R4 no out", int'(ren_vld), 0);
    set_dec(2'b11, 22, 23, 2'b00);
    tick();
    chk("R4 still blocked", int'(status), 2);
    set_dec(2'b11, 24, 25, 2'b00);
    tick();
    chk("R4 no out full", int'(ren_vld), 0);
    clr_dec(); iq_full = 1'b0;
    tick();
    chk("R5 unblocking", int'(status), 3);
    chk("R5 blk held", int'(blk_dec), 1);
    tick();
    chk("R2 first pair", int'(ren_seq), (21 << 8) | 20);
    chk("R2 first vld", int'(ren_vld), 3);
    tick();
    chk("R2 second pair", int'(ren_seq), (23 << 8) | 22);
    tick();
    chk("R2 third pair", int'(ren_seq), (25 << 8) | 24);
    chk("R5 running", int'(status), 1);
    chk("R5 blk drop", int'(blk_dec), 0);
    chk("R5 unblk pulse", int'(unblk_dec), 1);
    tick();
    chk("R5 pulse ends", int'(unblk_dec), 0);
    chk("R3 back idle", int'(status), 0);
    chk("R12 blocked cycles", int'(state_cyc[2*16 +: 16]), 3);
    chk("R12 unblocking cycles", int'(state_cyc[3*16 +: 16]), 3);
    disp_cnt = 6;
    tick(); disp_cnt = 0;
  endtask

  task automatic t_serial();
    set_dec(2'b11, 30, 31, 2'b10);
    tick(); clr_dec();
    chk("R6 run", int'(status), 1);
    tick();
    chk("R6 normal alone", int'(ren_vld), 1);
    chk("R6 normal seq", int'(ren_seq[7:0]), 30);
    tick();
    chk("R6 serialize stall", int'(status), 4);
    chk("R6 blk", int'(blk_dec), 1);
    chk("R6 held", int'(ren_vld), 0);
    tick();
    chk("R6 waits inflight", int'(status), 4);
    disp_cnt = 1;
    tick(); disp_cnt = 0;
    chk("R6 still waits", int'(ren_vld), 0);
    tick();
    chk("R6 emitted", int'(ren_vld), 1);
    chk("R6 seq", int'(ren_seq[7:0]), 31);
    chk("R6 ser flag", int'(ren_ser), 1);
    chk("R6 unblocking", int'(status), 3);
    tick();
    chk("R6 running", int'(status), 1);
    chk("R6 unblk", int'(unblk_dec), 1);
    disp_cnt = 1;
    tick(); disp_cnt = 0;
  endtask

  task automatic t_sq_block();
    iq_full = 1'b1;
    set_dec(2'b11, 40, 41, 2'b00);
    tick();
    chk("R7 blocked", int'(status), 2);
    set_dec(2'b11, 38, 45, 2'b00);
    sq_vld = 1'b1; sq_seq = 39;
    #1;
    chk("R10 mark", int'(sq_mark), 2);
    tick();
    clr_dec(); sq_vld = 1'b0; iq_full = 1'b0;
    chk("R7 squashing", int'(status), 5);
    chk("R7 unblk", int'(unblk_dec), 1);
    chk("R7 blk drop", int'(blk_dec), 0);
    chk("R7 no out", int'(ren_vld), 0);
    tick();
    chk("R7 running", int'(status), 1);
    chk("R7 unblk ends", int'(unblk_dec), 0);
    chk("R7 emptied", int'(ren_vld), 0);
    tick();
    chk("R10 older kept", int'(ren_vld), 1);
    chk("R10 older seq", int'(ren_seq[7:0]), 38);
    disp_cnt = 1;
    tick(); disp_cnt = 0;
    chk("R10 nothing else", int'(ren_vld), 0);
  endtask

  task automatic t_sq_ser_keep();
    set_dec(2'b01, 50, 0, 2'b01);
    tick(); clr_dec();
    tick();
    chk("R8 ser stall", int'(status), 4);
    rob_full = 1'b1;
    tick();
    chk("R8 held under stall", int'(ren_vld), 0);
    sq_vld = 1'b1; sq_seq = 60;
    tick(); sq_vld = 1'b0;
    chk("R8 squashing", int'(status), 5);
    chk("R8 no unblk", int'(unblk_dec), 0);
    chk("R8 blk drop", int'(blk_dec), 0);
    tick();
    chk("R8 back to ser", int'(status), 4);
    chk("R8 blk not yet", int'(blk_dec), 0);
    tick();
    chk("R8 blk again", int'(blk_dec), 1);
    rob_full = 1'b0;
    tick();
    chk("R8 kept emitted", int'(ren_vld), 1);
    chk("R8 kept seq", int'(ren_seq[7:0]), 50);
    chk("R8 ser flag", int'(ren_ser), 1);
    tick();
    chk("R8 unblk later", int'(unblk_dec), 1);
    disp_cnt = 1;
    tick(); disp_cnt = 0;
  endtask

  task automatic t_sq_ser_drop();
    set_dec(2'b01, 70, 0, 2'b01);
    tick(); clr_dec();
    tick();
    chk("R9 ser stall", int'(status), 4);
    rob_full = 1'b1;
    tick();
    sq_vld = 1'b1; sq_seq = 65;
    tick(); sq_vld = 1'b0; rob_full = 1'b0;
    chk("R9 squashing", int'(status), 5);
    chk("R9 unblk", int'(unblk_dec), 1);
    tick();
    chk("R9 running", int'(status), 1);
    chk("R9 no out", int'(ren_vld), 0);
    tick();
    chk("R9 dropped", int'(ren_vld), 0);
    chk("R9 idle", int'(status), 0);
  endtask

  task automatic t_events();
    chk("R12 squash cycles", int'(state_cyc[5*16 +: 16]), 3);
    lsq_full = 1'b1;
    tick(); lsq_full = 1'b0; regs_empty = 1'b1;
    tick(); regs_empty = 1'b0;
    chk("R4 no work no block", int'(status), 0);
    tick();
    chk("R13 rob", int'(full_evts[15:0]), 2);
    chk("R13 iq", int'(full_evts[31:16]), 2);
    chk("R13 lsq", int'(full_evts[47:32]), 1);
    chk("R13 regs", int'(full_evts[63:48]), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_flow();
    t_block();
    t_serial();
    t_sq_block();
    t_sq_ser_keep();
    t_sq_ser_drop();
    t_events();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule